// File: doc/BRIEF.md
# Split Two-Way Page Translation Cache

This block caches virtual-to-physical page translations for a processor core. It holds two independent tables: one serves instruction fetches, the other serves loads, stores and side-effect-free debug probes. Each table is two-way set associative over 4 KiB pages. The number of sets is a parameter. A set holds two ways and one bit that records the most recently used way.

A lookup presents a virtual address and an access kind. One cycle later the block reports a miss, a hit, or a "dirty update" result, together with the physical address. The dirty update result is given for a store that hits an entry whose change flag is still clear. The block sets that flag in its own copy and returns this result so that the page-table walker can also update the copy in memory. A walker refills the table after a miss through the fill port. An invalidate port drops a whole set, selected by a virtual address, in both tables at once.

Top module: `xlate_tlb`

## Requirements
- R1: Reset marks every way of every set in both tables invalid, using the all-ones tag, and holds `rs_valid` low. Every lookup after reset reports a miss.
- R2: A lookup presented on `lk_valid` produces exactly one result with `rs_valid` high on the following cycle. `rs_valid` is low in every cycle that does not follow a request.
- R3: Access kinds are encoded 0 = read, 1 = write, 2 = fetch, 3 = probe. Fetch lookups and fetch fills use only the instruction table. Read, write and probe lookups, and read and write fills, use only the data table.
- R4: Result codes are 0 = miss, 1 = hit, 2 = dirty update, and code 3 never appears. On a hit or a dirty update, `rs_pa` is PTE bits 31:12 followed by virtual address bits 11:0. On a miss, `rs_pa` is zero.
- R5: The page tag is virtual address bits 31:12. The set index is the low log2(SETS) bits of the tag. A different tag that maps to the same set misses.
- R6: A write lookup that hits an entry whose PTE bit 7 is clear reports result 2 and sets bit 7 in the cached PTE, so the next write to that page reports 1. Reads, fetches and probes never report 2.
- R7: A fill goes to way 1 when the set's recent bit is 0 and way 0 holds a valid tag, and to way 0 otherwise. The recent bit then names the filled way. A plain hit from a read, write or fetch sets the recent bit to the way that hit.
- R8: A probe lookup leaves the recent bit unchanged. A fill presented with the probe kind is discarded.
- R9: An invalidate clears both ways of the addressed set in both tables and leaves other sets intact.
- R10: When a fill and a lookup address the same set in the same cycle, the fill's choice of way and its recent-bit value take effect, and the lookup's recent-bit update is dropped. The lookup still reports against the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_kind | input | 2 | Lookup access kind (0 read, 1 write, 2 fetch, 3 probe) |
| lk_va | input | 32 | Lookup virtual address |
| rs_valid | output | 1 | Result valid, one cycle after the request |
| rs_status | output | 2 | 0 miss, 1 hit, 2 dirty update |
| rs_pa | output | 32 | Translated physical address, zero on a miss |
| fill_valid | input | 1 | Refill request from the walker |
| fill_kind | input | 2 | Access kind that caused the walk; selects the table |
| fill_va | input | 32 | Virtual address being refilled |
| fill_pte | input | 32 | Second PTE word; bits 31:12 give the page base, bit 7 is the change flag |
| inv_valid | input | 1 | Invalidate request |
| inv_va | input | 32 | Address whose set is invalidated in both tables |

## Verification
Every set of both tables is swept with a translation in each table. The sweep checks that the tables stay separate and that the page offset is carried through. A design that shared a single table would report fetch hits on data pages. The replacement order is driven through fill, hit, fill sequences whose victims are known in advance. Three faults show up as the wrong page surviving: a mishandled recent bit, a probe that touches the recent bit, or a lookup that overrides a fill in the same cycle. The change-flag path is checked so that a store to a clean page gives a dirty update once and then plain hits. Invalidation is checked so that sets outside the target set survive, and a design that cleared only one table leaves the other table's page still hitting.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W  = 32;
    localparam int PG_SH = 12;
    localparam int TAG_W = VA_W - PG_SH;
    localparam int PTE_W = 32;
    localparam int CHG_BIT = 7;
    localparam logic [TAG_W-1:0] TAG_NONE = '1;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_PROBE = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        RES_MISS  = 2'd0,
        RES_HIT   = 2'd1,
        RES_DIRTY = 2'd2
    } res_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [PTE_W-1:0] pte;
        logic [TAG_W-1:0] ppn;
    } way_t;

    typedef struct packed {
        way_t [1:0] way;
        logic       recent;
    } set_t;

    typedef struct packed {
        logic             valid;
        logic [1:0]       status;
        logic [VA_W-1:0]  pa;
    } rsp_t;
endpackage

// File: rtl/tlb_way_cmp.sv
module tlb_way_cmp
    import tlb_pkg::*;
(
    input  logic [1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]      probe_tag,
    output logic [1:0]            match
);
    for (genvar w = 0; w < 2; w++) begin : g_way
        assign match[w] = (tags[w] == probe_tag) && (probe_tag != TAG_NONE);
    end
endmodule

// File: rtl/tlb_bank.sv
module tlb_bank
    import tlb_pkg::*;
#(
    parameter int SETS = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lk_en,
    input  logic            lk_write,
    input  logic            lk_touch,
    input  logic [VA_W-1:0] lk_va,
    input  logic            fill_en,
    input  logic [VA_W-1:0] fill_va,
    input  logic [PTE_W-1:0] fill_pte,
    input  logic            inv_en,
    input  logic [VA_W-1:0] inv_va,
    output logic            hit,
    output logic            dirty_req,
    output logic [VA_W-1:0] pa
);
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;

    set_t [SETS-1:0] st_q, st_d;

    logic [TAG_W-1:0] lk_tag, fill_tag;
    logic [IDX_W-1:0] lk_idx, fill_idx, inv_idx;
    logic [1:0]       match;
    logic             hit_way, any_match, victim;
    way_t             sel;
    set_t             cur;

    assign lk_tag   = lk_va[VA_W-1:PG_SH];
    assign fill_tag = fill_va[VA_W-1:PG_SH];
    assign lk_idx   = lk_va[PG_SH +: IDX_W];
    assign fill_idx = fill_va[PG_SH +: IDX_W];
    assign inv_idx  = inv_va[PG_SH +: IDX_W];
    assign cur      = st_q[lk_idx];

    logic unused_bits;
    assign unused_bits = ^{inv_va[PG_SH-1:0], inv_va[VA_W-1:PG_SH+IDX_W],
                           fill_va[PG_SH-1:0]};

    tlb_way_cmp u_cmp (
        .tags      ({cur.way[1].tag, cur.way[0].tag}),
        .probe_tag (lk_tag),
        .match     (match)
    );

    assign any_match = |match;
    assign hit_way   = match[1] & ~match[0];
    assign sel       = cur.way[hit_way];
    assign dirty_req = lk_en & any_match & lk_write & ~sel.pte[CHG_BIT];
    assign hit       = lk_en & any_match & ~dirty_req;
    assign pa        = {sel.ppn, lk_va[PG_SH-1:0]};
    assign victim    = ~st_q[fill_idx].recent && (st_q[fill_idx].way[0].tag != TAG_NONE);

    always_comb begin
        st_d = st_q;
        // lookup side effects first; fill and invalidate below override them
        if (dirty_req) begin
            st_d[lk_idx].way[hit_way].pte[CHG_BIT] = 1'b1;
        end else if (hit && lk_touch) begin
            st_d[lk_idx].recent = hit_way;
        end
        if (fill_en) begin
            st_d[fill_idx].way[victim].tag = fill_tag;
            st_d[fill_idx].way[victim].pte = fill_pte;
            st_d[fill_idx].way[victim].ppn = fill_pte[PTE_W-1:PG_SH];
            st_d[fill_idx].recent          = victim;
        end
        if (inv_en) begin
            st_d[inv_idx].way[0].tag = TAG_NONE;
            st_d[inv_idx].way[1].tag = TAG_NONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                st_q[s].recent <= 1'b0;
                for (int w = 0; w < 2; w++) begin
                    st_q[s].way[w].tag <= TAG_NONE;
                    st_q[s].way[w].pte <= '0;
                    st_q[s].way[w].ppn <= '0;
                end
            end
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/xlate_tlb.sv
module xlate_tlb
    import tlb_pkg::*;
#(
    parameter int SETS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lk_valid,
    input  logic [1:0]  lk_kind,
    input  logic [31:0] lk_va,
    output logic        rs_valid,
    output logic [1:0]  rs_status,
    output logic [31:0] rs_pa,
    input  logic        fill_valid,
    input  logic [1:0]  fill_kind,
    input  logic [31:0] fill_va,
    input  logic [31:0] fill_pte,
    input  logic        inv_valid,
    input  logic [31:0] inv_va
);
    localparam int NBANK = 2;   // bank 0 = data, bank 1 = instruction

    logic [NBANK-1:0] b_hit, b_dirty;
    logic [VA_W-1:0]  b_pa [NBANK];
    logic             lk_fetch, fill_fetch, fill_ok;
    rsp_t             rsp_q, rsp_d;

    assign lk_fetch   = (lk_kind == ACC_FETCH);
    assign fill_fetch = (fill_kind == ACC_FETCH);
    assign fill_ok    = fill_valid && (fill_kind != ACC_PROBE);

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        localparam logic IS_I = (b == 1);
        tlb_bank #(.SETS(SETS)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .lk_en     (lk_valid && (lk_fetch == IS_I)),
            .lk_write  (lk_kind == ACC_WRITE),
            .lk_touch  (lk_kind != ACC_PROBE),
            .lk_va     (lk_va),
            .fill_en   (fill_ok && (fill_fetch == IS_I)),
            .fill_va   (fill_va),
            .fill_pte  (fill_pte),
            .inv_en    (inv_valid),
            .inv_va    (inv_va),
            .hit       (b_hit[b]),
            .dirty_req (b_dirty[b]),
            .pa        (b_pa[b])
        );
    end

    always_comb begin
        rsp_d        = '0;
        rsp_d.valid  = lk_valid;
        if (lk_valid) begin
            if (b_hit[lk_fetch]) begin
                rsp_d.status = RES_HIT;
                rsp_d.pa     = b_pa[lk_fetch];
            end else if (b_dirty[lk_fetch]) begin
                rsp_d.status = RES_DIRTY;
                rsp_d.pa     = b_pa[lk_fetch];
            end else begin
                rsp_d.status = RES_MISS;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rs_valid  = rsp_q.valid;
    assign rs_status = rsp_q.status;
    assign rs_pa     = rsp_q.pa;
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        lk_valid,
    input logic [1:0]  lk_kind,
    input logic [31:0] lk_va,
    input logic        rs_valid,
    input logic [1:0]  rs_status,
    input logic [31:0] rs_pa,
    input logic        fill_valid,
    input logic        inv_valid,
    input logic [31:0] inv_va
);
    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid);
    p_rsp_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rs_valid);
    p_code_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> rs_status != 2'd3);
    p_miss_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_status == 2'd0) |-> rs_pa == 32'd0);
    p_offset_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> (rs_status == 2'd0 || rs_pa[11:0] == $past(lk_va[11:0])));
    p_dirty_only_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_kind != 2'd1) |=> rs_status != 2'd2);
    p_inv_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && $past(inv_valid) && !$past(fill_valid)
         && $past(inv_va[31:12]) == lk_va[31:12]) |=> rs_status == 2'd0);
endmodule

bind xlate_tlb tlb_checker u_chk (.*);

// File: tb/sim_xlate_tlb.sv
module sim_xlate_tlb;
    localparam int SETS = 16;
    localparam logic [1:0] K_RD = 2'd0, K_WR = 2'd1, K_IF = 2'd2, K_PR = 2'd3;
    localparam logic [1:0] S_MISS = 2'd0, S_HIT = 2'd1, S_DIRTY = 2'd2;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        lk_valid = 1'b0, fill_valid = 1'b0, inv_valid = 1'b0;
    logic [1:0]  lk_kind = '0, fill_kind = '0;
    logic [31:0] lk_va = '0, fill_va = '0, fill_pte = '0, inv_va = '0;
    logic        rs_valid;
    logic [1:0]  rs_status;
    logic [31:0] rs_pa;

    int total = 0, fails = 0;

    always #10 clk = ~clk;

    xlate_tlb #(.SETS(SETS)) u0 (.*);

    function automatic logic [31:0] mkva(input logic [15:0] hi, input int set, input logic [11:0] off);
        return {hi, 4'(set), off};
    endfunction
    function automatic logic [31:0] mkpte(input logic [19:0] ppn, input logic chg);
        return {ppn, 4'b0, chg, 7'b0};
    endfunction

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic lookup(input logic [1:0] k, input logic [31:0] va,
                          input logic [1:0] est, input logic [19:0] eppn, input string req);
        logic [31:0] epa;
        @(negedge clk);
        lk_valid = 1'b1; lk_kind = k; lk_va = va;
        @(negedge clk);
        lk_valid = 1'b0;
        epa = (est == S_MISS) ? 32'd0 : {eppn, va[11:0]};
        check(rs_valid && rs_status == est && rs_pa == epa, req,
              {rs_valid, 5'd0, rs_status, rs_pa[23:0]}, {1'b1, 5'd0, est, epa[23:0]});
    endtask

    task automatic fill(input logic [1:0] k, input logic [31:0] va, input logic [31:0] pte);
        @(negedge clk);
        fill_valid = 1'b1; fill_kind = k; fill_va = va; fill_pte = pte;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic inval(input logic [31:0] va);
        @(negedge clk);
        inv_valid = 1'b1; inv_va = va;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!rs_valid, "R1 reset valid low", {31'd0, rs_valid}, 32'd0);
        rst_n = 1'b1;

        // R1: everything misses after reset, in both tables
        for (int s = 0; s < SETS; s++) begin
            lookup(K_RD, mkva(16'h1234, s, 12'h010), S_MISS, 20'h0, "R1 data empty");
            lookup(K_IF, mkva(16'h5678, s, 12'h020), S_MISS, 20'h0, "R1 instr empty");
        end

        // R3/R4/R5 sweep: one page per set in each table
        for (int s = 0; s < SETS; s++) begin
            fill(K_RD, mkva(16'h1234, s, 12'h0), mkpte(20'h80000 + 20'(s * 3), 1'b1));
            fill(K_IF, mkva(16'h5678, s, 12'h0), mkpte(20'h90000 + 20'(s), 1'b1));
        end
        for (int s = 0; s < SETS; s++) begin
            lookup(K_RD, mkva(16'h1234, s, 12'(s * 16 + 4)), S_HIT, 20'h80000 + 20'(s * 3), "R4 data pa");
            lookup(K_PR, mkva(16'h1234, s, 12'hABC), S_HIT, 20'h80000 + 20'(s * 3), "R3 probe uses data");
            lookup(K_IF, mkva(16'h1234, s, 12'h004), S_MISS, 20'h0, "R3 fetch ignores data");
            lookup(K_IF, mkva(16'h5678, s, 12'hFFC), S_HIT, 20'h90000 + 20'(s), "R3 instr pa");
            lookup(K_RD, mkva(16'h5678, s, 12'h000), S_MISS, 20'h0, "R3 read ignores instr");
            lookup(K_RD, mkva(16'h1235, s, 12'h000), S_MISS, 20'h0, "R5 tag mismatch");
        end

        // R9: invalidate set 5 in both tables, set 6 untouched
        inval(mkva(16'hDEAD, 5, 12'h123));
        lookup(K_RD, mkva(16'h1234, 5, 12'h0), S_MISS, 20'h0, "R9 data cleared");
        lookup(K_IF, mkva(16'h5678, 5, 12'h0), S_MISS, 20'h0, "R9 instr cleared");
        lookup(K_RD, mkva(16'h1234, 6, 12'h0), S_HIT, 20'h80000 + 20'd18, "R9 other set kept");
        lookup(K_IF, mkva(16'h5678, 6, 12'h0), S_HIT, 20'h90006, "R9 other instr kept");

        // R6: change flag
        fill(K_WR, mkva(16'h0C0C, 5, 12'h0), mkpte(20'h33333, 1'b0));
        lookup(K_RD, mkva(16'h0C0C, 5, 12'h44), S_HIT, 20'h33333, "R6 read clean is hit");
        lookup(K_WR, mkva(16'h0C0C, 5, 12'h48), S_DIRTY, 20'h33333, "R6 write clean dirty");
        lookup(K_WR, mkva(16'h0C0C, 5, 12'h4C), S_HIT, 20'h33333, "R6 second write hit");
        lookup(K_WR, mkva(16'h1234, 6, 12'h0), S_HIT, 20'h80000 + 20'd18, "R6 write to dirty page");

        // R7: replacement order in set 9
        inval(mkva(16'h0, 9, 12'h0));
        fill(K_RD, mkva(16'hA001, 9, 12'h0), mkpte(20'hA0001, 1'b1));   // way0
        fill(K_RD, mkva(16'hA002, 9, 12'h0), mkpte(20'hA0002, 1'b1));   // way1
        fill(K_RD, mkva(16'hA003, 9, 12'h0), mkpte(20'hA0003, 1'b1));   // way0, evicts A001
        lookup(K_RD, mkva(16'hA001, 9, 12'h0), S_MISS, 20'h0, "R7 first victim");
        lookup(K_RD, mkva(16'hA003, 9, 12'h0), S_HIT, 20'hA0003, "R7 third kept");
        lookup(K_RD, mkva(16'hA002, 9, 12'h0), S_HIT, 20'hA0002, "R7 hit marks way1");
        fill(K_RD, mkva(16'hA004, 9, 12'h0), mkpte(20'hA0004, 1'b1));   // way0, evicts A003
        lookup(K_RD, mkva(16'hA003, 9, 12'h0), S_MISS, 20'h0, "R7 recent-based victim");
        lookup(K_RD, mkva(16'hA002, 9, 12'h0), S_HIT, 20'hA0002, "R7 recent way kept");
        lookup(K_RD, mkva(16'hA004, 9, 12'h0), S_HIT, 20'hA0004, "R7 new page");

        // R8: probe keeps recent bit; probe fill dropped
        inval(mkva(16'h0, 10, 12'h0));
        fill(K_RD, mkva(16'hB001, 10, 12'h0), mkpte(20'hB0001, 1'b1));
        fill(K_RD, mkva(16'hB002, 10, 12'h0), mkpte(20'hB0002, 1'b1));
        lookup(K_RD, mkva(16'hB001, 10, 12'h0), S_HIT, 20'hB0001, "R8 setup hit");
        lookup(K_PR, mkva(16'hB002, 10, 12'h0), S_HIT, 20'hB0002, "R8 probe hit");
        fill(K_RD, mkva(16'hB003, 10, 12'h0), mkpte(20'hB0003, 1'b1));  // way1 evicts B002
        lookup(K_RD, mkva(16'hB002, 10, 12'h0), S_MISS, 20'h0, "R8 probe left recent");
        lookup(K_RD, mkva(16'hB001, 10, 12'h0), S_HIT, 20'hB0001, "R8 way0 kept");
        inval(mkva(16'h0, 11, 12'h0));
        fill(K_PR, mkva(16'hB004, 11, 12'h0), mkpte(20'hB0004, 1'b1));
        lookup(K_PR, mkva(16'hB004, 11, 12'h0), S_MISS, 20'h0, "R8 probe fill dropped");

        // R10: fill and lookup to the same set in one cycle
        inval(mkva(16'h0, 12, 12'h0));
        fill(K_RD, mkva(16'hC001, 12, 12'h0), mkpte(20'hC0001, 1'b1));
        fill(K_RD, mkva(16'hC002, 12, 12'h0), mkpte(20'hC0002, 1'b1));
        lookup(K_RD, mkva(16'hC001, 12, 12'h0), S_HIT, 20'hC0001, "R10 setup");
        @(negedge clk);
        lk_valid = 1'b1; lk_kind = K_RD; lk_va = mkva(16'hC001, 12, 12'h0);
        fill_valid = 1'b1; fill_kind = K_RD; fill_va = mkva(16'hC003, 12, 12'h0);
        fill_pte = mkpte(20'hC0003, 1'b1);
        @(negedge clk);
        lk_valid = 1'b0; fill_valid = 1'b0;
        check(rs_valid && rs_status == S_HIT && rs_pa == 32'hC0001000, "R10 lookup result",
              rs_pa, 32'hC0001000);
        fill(K_RD, mkva(16'hC004, 12, 12'h0), mkpte(20'hC0004, 1'b1)); // way0 evicts C001
        lookup(K_RD, mkva(16'hC001, 12, 12'h0), S_MISS, 20'h0, "R10 fill recent wins");
        lookup(K_RD, mkva(16'hC003, 12, 12'h0), S_HIT, 20'hC0003, "R10 same-cycle fill");
        lookup(K_RD, mkva(16'hC004, 12, 12'h0), S_HIT, 20'hC0004, "R10 later fill");

        // R2: quiet cycle gives no result
        @(negedge clk);
        check(!rs_valid, "R2 no request no result", {31'd0, rs_valid}, 32'd0);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule